// File: doc/BRIEF.md
# Stop-Committed I2C Channel Switch Controller

This block is an I2C target that steers four downstream bus segments through external pass switches. It oversamples the upstream SCL and SDA lines with a fast system clock and finds START, repeated START and STOP conditions. It answers to a 7-bit address whose upper four bits are fixed at 1110 and whose lower three bits come from strap pins. A master writes one configuration byte to select a channel or to disconnect every channel. A master can also read back the selection that is currently in force.

A written configuration does not reach the channel-enable outputs straight away. It is held as a pending value, and a STOP moves it into the active register. If the master sends a repeated START instead of a STOP, the pending value is thrown away. The old selection then stays in force, so any traffic the master sends after the repeated START goes through the channel that was already connected.

Top module: `i2c_chsel_switch`

## Requirements
- R1: While reset is asserted, all four channel enables are low and SDA is not driven.
- R2: The target acknowledges an address byte whose upper seven bits equal 1110 followed by the three strap bits. Bit 0 of the address byte is the direction bit, where 0 means write and 1 means read. Any other address gets no acknowledge. After a mismatch the target ignores the bus until the next START or STOP, and the channel outputs do not change.
- R3: After a configuration byte has been written and acknowledged, the channel enables keep their old value until a STOP is seen.
- R4: A STOP that follows an acknowledged configuration byte applies it. Bit 2 is the enable bit and bits 1:0 give the channel number. With the enable bit at 1, only the enable output whose index equals bits 1:0 is high.
- R5: A repeated START after a configuration byte discards the pending value. A later STOP leaves the earlier selection on the outputs.
- R6: A configuration with bit 2 at 0 turns every channel off once committed. At no time is more than one channel enable high.
- R7: A read returns the active configuration, with bits 7:3 as zero, bit 2 as the enable bit and bits 1:0 as the channel. It never returns a pending value that has not been committed. Bits 7:3 of a written byte have no effect.
- R8: A STOP with no configuration pending leaves the channel enables unchanged.
- R9: When the master does not acknowledge a read byte, the target releases SDA and drives nothing more until the next START or STOP.
- R10: Within one system clock after a START or STOP has been detected, the target releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Upstream SCL level |
| sda_i | input | 1 | Upstream SDA level as seen on the wired bus |
| sda_oe | output | 1 | When high, the open-drain SDA driver pulls the line low |
| addr_strap | input | 3 | Low three bits of the target address |
| chan_en | output | 4 | Enable signals for the four downstream pass switches |

## Verification
The bench targets the window between the configuration byte's ACK and the STOP. It checks the outputs in that window, because a design that commits when the write happens would switch channels there. It sends a repeated START after a configuration byte, addresses another device and then sends a STOP. A design that commits on any STOP, or that keeps the pending flag across a START, would move to the discarded channel. Reads issued while a value is pending catch a design that returns the pending register instead of the active one. Stray upper bits in a written byte catch a design that stores them. Mismatched addresses and a master NACK on a read catch a target that keeps driving SDA or keeps accepting bytes when it should be idle.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [3:0]  ADDR_HI = 4'b1110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_SKIP
  } tgt_state_e;
endpackage

// File: rtl/chsel_sync.sv
module chsel_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_lvl,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_ff_q, sda_ff_q;
  logic              scl_prev_q, sda_prev_q;
  logic              scl_now, sda_now;

  assign scl_now = scl_ff_q[STAGES-1];
  assign sda_now = sda_ff_q[STAGES-1];

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff_q <= '1;
          sda_ff_q <= '1;
        end else begin
          scl_ff_q <= {scl_ff_q[STAGES-2:0], scl_i};
          sda_ff_q <= {sda_ff_q[STAGES-2:0], sda_i};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff_q <= '1;
          sda_ff_q <= '1;
        end else begin
          scl_ff_q <= scl_i;
          sda_ff_q <= sda_i;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_now;
      sda_prev_q <= sda_now;
    end
  end

  // SDA moving while SCL stays high marks a bus condition
  assign scl_rise  =  scl_now & ~scl_prev_q;
  assign scl_fall  = ~scl_now &  scl_prev_q;
  assign sda_lvl   =  sda_now;
  assign start_evt =  scl_now & scl_prev_q &  sda_prev_q & ~sda_now;
  assign stop_evt  =  scl_now & scl_prev_q & ~sda_prev_q &  sda_now;
endmodule

// File: rtl/chsel_target.sv
module chsel_target
  import chsel_pkg::*;
#(
  parameter int unsigned CFG_W   = 3,
  parameter int unsigned STRAP_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               sda_lvl,
  input  logic               start_evt,
  input  logic               stop_evt,
  input  logic [STRAP_W-1:0] strap,
  input  logic [CFG_W-1:0]   rd_cfg,
  output logic               sda_oe,
  output logic               wr_valid,
  output logic [CFG_W-1:0]   wr_cfg
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  tgt_state_e          st_q, st_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [BYTE_W-1:0]   sh_q, sh_d;
  logic                rw_q, rw_d;
  logic                oe_q, oe_d;
  logic                mack_q, mack_d;
  logic [BYTE_W-1:0]   rd_byte;
  logic                addr_hit;

  assign rd_byte  = {{(BYTE_W-CFG_W){1'b0}}, rd_cfg};
  assign addr_hit = (sh_q[BYTE_W-1:1] == {ADDR_HI, strap});

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    rw_d     = rw_q;
    oe_d     = oe_q;
    mack_d   = mack_q;
    wr_valid = 1'b0;
    if (stop_evt) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else if (start_evt) begin
      st_d  = ST_ADDR;
      cnt_d = '0;
      sh_d  = '0;
      oe_d  = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_WDATA: begin
          if (scl_rise && cnt_q < CNT_FULL) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_lvl};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            if (st_q == ST_WDATA) begin
              st_d     = ST_WACK;
              oe_d     = 1'b1;
              wr_valid = 1'b1;
            end else if (addr_hit) begin
              st_d = ST_ADDR_ACK;
              oe_d = 1'b1;
              rw_d = sh_q[0];
            end else begin
              st_d = ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              st_d = ST_RDATA;
              sh_d = rd_byte;
              oe_d = ~rd_byte[BYTE_W-1];
            end else begin
              st_d = ST_WDATA;
              sh_d = '0;
              oe_d = 1'b0;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            st_d  = ST_WDATA;
            cnt_d = '0;
            oe_d  = 1'b0;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              st_d = ST_RACK;
              oe_d = 1'b0;
            end else begin
              cnt_d = cnt_q + 1'b1;
              sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              oe_d  = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_lvl;
          end else if (scl_fall) begin
            cnt_d = '0;
            if (mack_q) begin
              st_d = ST_RDATA;
              sh_d = rd_byte;
              oe_d = ~rd_byte[BYTE_W-1];
            end else begin
              st_d = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      rw_q   <= 1'b0;
      oe_q   <= 1'b0;
      mack_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      rw_q   <= rw_d;
      oe_q   <= oe_d;
      mack_q <= mack_d;
    end
  end

  assign sda_oe = oe_q;
  assign wr_cfg = sh_q[CFG_W-1:0];
endmodule

// File: rtl/chsel_commit.sv
module chsel_commit #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned SEL_W  = $clog2(NUM_CH),
  parameter int unsigned CFG_W  = SEL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [CFG_W-1:0]  wr_cfg,
  input  logic              start_evt,
  input  logic              stop_evt,
  output logic [CFG_W-1:0]  act_cfg,
  output logic              pend_v,
  output logic [NUM_CH-1:0] chan_en
);
  logic [CFG_W-1:0] pend_q, pend_d;
  logic [CFG_W-1:0] act_q, act_d;
  logic             pv_q, pv_d;
  logic             act_en;

  always_comb begin
    pend_d = pend_q;
    pv_d   = pv_q;
    act_en = 1'b0;
    act_d  = pend_q;
    if (stop_evt) begin
      act_en = pv_q;
      pv_d   = 1'b0;
    end else if (start_evt) begin
      pv_d = 1'b0;
    end else if (wr_valid) begin
      pend_d = wr_cfg;
      pv_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      pv_q   <= 1'b0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      pv_q   <= pv_d;
      if (act_en) act_q <= act_d;
    end
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
      assign chan_en[g] = act_q[SEL_W] && (act_q[SEL_W-1:0] == SEL_W'(g));
    end
  endgenerate

  assign act_cfg = act_q;
  assign pend_v  = pv_q;
endmodule

// File: rtl/i2c_chsel_switch.sv
module i2c_chsel_switch #(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned STRAP_W     = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] addr_strap,
  output logic [NUM_CH-1:0]  chan_en
);
  localparam int unsigned SEL_W = $clog2(NUM_CH);
  localparam int unsigned CFG_W = SEL_W + 1;

  logic [1:0]       rst_ff_q;
  logic             rst_s_n;
  logic             scl_rise, scl_fall, sda_lvl;
  logic             start_evt, stop_evt;
  logic             wr_valid, pend_v;
  logic [CFG_W-1:0] wr_cfg, act_cfg;

  // assert at once, release two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff_q <= 2'b00;
    else        rst_ff_q <= {rst_ff_q[0], 1'b1};
  end
  assign rst_s_n = rst_ff_q[1];

  chsel_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  chsel_target #(.CFG_W(CFG_W), .STRAP_W(STRAP_W)) u_tgt (
    .clk(clk), .rst_n(rst_s_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .start_evt(start_evt), .stop_evt(stop_evt),
    .strap(addr_strap), .rd_cfg(act_cfg), .sda_oe(sda_oe),
    .wr_valid(wr_valid), .wr_cfg(wr_cfg)
  );

  chsel_commit #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .CFG_W(CFG_W)) u_commit (
    .clk(clk), .rst_n(rst_s_n), .wr_valid(wr_valid), .wr_cfg(wr_cfg),
    .start_evt(start_evt), .stop_evt(stop_evt), .act_cfg(act_cfg),
    .pend_v(pend_v), .chan_en(chan_en)
  );
endmodule

// File: rtl/chsel_checker.sv
module chsel_checker #(
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] chan_en,
  input logic              sda_oe,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              pend_v
);
  p_rst_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (chan_en == '0 && !sda_oe));

  p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_en));

  p_commit_on_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_en) |-> $past(stop_evt));

  p_drop_on_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !pend_v);

  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |=> !sda_oe);
endmodule

bind i2c_chsel_switch chsel_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .sda_oe(sda_oe),
  .start_evt(start_evt), .stop_evt(stop_evt), .pend_v(pend_v)
);

// File: tb/i2c_chsel_switch_bench.sv
module i2c_chsel_switch_bench;
  localparam int Q = 5;

  logic       clk;
  logic       rst_n;
  logic       scl_m, sda_m;
  logic       sda_oe;
  logic       sda_bus;
  logic [2:0] strap;
  logic [3:0] chan_en;

  int checks;
  int errors;
  logic [2:0] mdl_cfg;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_chsel_switch u_i2c_chsel_switch (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .addr_strap(strap), .chan_en(chan_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [3:0] exp_chan(input logic [2:0] c);
    return c[2] ? (4'b0001 << c[1:0]) : 4'b0000;
  endfunction

  function automatic logic [7:0] exp_read(input logic [2:0] c);
    return {5'b00000, c};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; w(Q);
    scl_m = 1'b1; w(Q);
    sda_m = 1'b0; w(Q);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; w(Q);
    scl_m = 1'b1; w(Q);
    sda_m = 1'b1; w(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(Q);
      scl_m = 1'b1; w(2*Q);
      scl_m = 1'b0; w(Q);
    end
    sda_m = 1'b1; w(Q);
    scl_m = 1'b1; w(Q);
    ack = ~sda_bus;
    w(Q);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; w(Q);
      scl_m = 1'b1; w(Q);
      b[i] = sda_bus;
      w(Q);
      scl_m = 1'b0; w(Q);
    end
    sda_m = ~mack; w(Q);
    scl_m = 1'b1; w(2*Q);
    scl_m = 1'b0; w(Q);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] own_addr(input logic rd);
    return {4'b1110, strap, rd};
  endfunction

  task automatic do_read(input string req, input logic [7:0] exp);
    logic ack;
    logic [7:0] b;
    send_byte(own_addr(1'b1), ack);
    chk(ack, "R2", "read address ack", 32'(ack), 1);
    recv_byte(1'b0, b);
    chk(b == exp, req, "read data", 32'(b), 32'(exp));
    w(2*Q);
    chk(!sda_oe, "R9", "sda released after nack", 32'(sda_oe), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] cfg;
    checks = 0;
    errors = 0;
    void'($urandom(32'h5eed_1234));
    scl_m = 1'b1;
    sda_m = 1'b1;
    strap = 3'b010;
    rst_n = 1'b0;
    mdl_cfg = 3'b000;
    w(4);
    chk(chan_en == 4'b0, "R1", "channels off in reset", 32'(chan_en), 0);
    chk(!sda_oe, "R1", "sda idle in reset", 32'(sda_oe), 0);
    rst_n = 1'b1;
    w(10);

    // R2 R3 R4: write en+ch1, check hold before stop, commit after
    bus_start;
    send_byte(own_addr(1'b0), ack);
    chk(ack, "R2", "write address ack", 32'(ack), 1);
    send_byte(8'h05, ack);
    chk(ack, "R4", "config byte ack", 32'(ack), 1);
    w(3*Q);
    chk(chan_en == 4'b0, "R3", "no change before stop", 32'(chan_en), 0);
    bus_stop;
    mdl_cfg = 3'b101;
    chk(chan_en == exp_chan(mdl_cfg), "R4", "commit on stop", 32'(chan_en), 32'(exp_chan(mdl_cfg)));

    // R7 R9 read back active
    bus_start;
    do_read("R7", exp_read(mdl_cfg));
    bus_stop;

    // R5: repeated start discards pending, traffic to other device, stop
    bus_start;
    send_byte(own_addr(1'b0), ack);
    send_byte(8'h06, ack);
    bus_start;
    send_byte(8'hA0, ack);
    chk(!ack, "R2", "other device not acked", 32'(ack), 0);
    chk(chan_en == exp_chan(mdl_cfg), "R5", "old channel during rstart traffic", 32'(chan_en), 32'(exp_chan(mdl_cfg)));
    bus_stop;
    chk(chan_en == exp_chan(mdl_cfg), "R5", "pending dropped after rstart", 32'(chan_en), 32'(exp_chan(mdl_cfg)));

    // R7: read while pending shows active
    bus_start;
    send_byte(own_addr(1'b0), ack);
    send_byte(8'h07, ack);
    bus_start;
    do_read("R7", exp_read(mdl_cfg));
    bus_stop;
    chk(chan_en == exp_chan(mdl_cfg), "R5", "stop after read keeps old", 32'(chan_en), 32'(exp_chan(mdl_cfg)));

    // R6 R7: enable bit clear with upper bits set
    bus_start;
    send_byte(own_addr(1'b0), ack);
    send_byte(8'hFB, ack);
    bus_stop;
    mdl_cfg = 3'b011;
    chk(chan_en == 4'b0, "R6", "disable all", 32'(chan_en), 0);
    bus_start;
    do_read("R7", exp_read(mdl_cfg));
    bus_stop;

    // R8: bare start/stop
    bus_start;
    send_byte(own_addr(1'b0), ack);
    send_byte(8'h04, ack);
    bus_stop;
    mdl_cfg = 3'b100;
    bus_start;
    bus_stop;
    chk(chan_en == exp_chan(mdl_cfg), "R8", "stop without pending", 32'(chan_en), 32'(exp_chan(mdl_cfg)));

    // R2: wrong strap address is ignored, including following byte
    bus_start;
    send_byte({4'b1110, ~strap, 1'b0}, ack);
    chk(!ack, "R2", "mismatch nack", 32'(ack), 0);
    send_byte(8'h07, ack);
    chk(!ack, "R2", "ignored byte nack", 32'(ack), 0);
    bus_stop;
    chk(chan_en == exp_chan(mdl_cfg), "R2", "mismatch no effect", 32'(chan_en), 32'(exp_chan(mdl_cfg)));

    // random mix
    for (int t = 0; t < 40; t++) begin
      int kind;
      kind = int'($urandom_range(0, 3));
      cfg = 8'($urandom);
      bus_start;
      if (kind == 0) begin
        send_byte(own_addr(1'b0), ack);
        send_byte(cfg, ack);
        bus_stop;
        mdl_cfg = cfg[2:0];
        chk(chan_en == exp_chan(mdl_cfg), "R4", "random commit", 32'(chan_en), 32'(exp_chan(mdl_cfg)));
      end else if (kind == 1) begin
        send_byte(own_addr(1'b0), ack);
        send_byte(cfg, ack);
        bus_start;
        send_byte(8'h90, ack);
        bus_stop;
        chk(chan_en == exp_chan(mdl_cfg), "R5", "random rstart drop", 32'(chan_en), 32'(exp_chan(mdl_cfg)));
      end else if (kind == 2) begin
        do_read("R7", exp_read(mdl_cfg));
        bus_stop;
      end else begin
        send_byte({4'b1110, strap ^ 3'($urandom_range(1, 7)), 1'b0}, ack);
        chk(!ack, "R2", "random mismatch nack", 32'(ack), 0);
        send_byte(cfg, ack);
        bus_stop;
        chk(chan_en == exp_chan(mdl_cfg), "R8", "random no commit", 32'(chan_en), 32'(exp_chan(mdl_cfg)));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule